// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block runs in-band flow control for a single asynchronous serial channel. It works in two directions. For the local receiver, it compares the receive-FIFO fill level with a programmable upper and lower threshold. It then asks the transmitter to insert a halt code or a resume code so the remote sender slows down or restarts. For the local transmitter, it examines every incoming character against programmed halt/resume codes, and it gates the draining of the transmit FIFO when the far end asks for a pause.

There are two programmable code pairs. Pair one holds a resume code and a halt code, and pair two holds another resume code and halt code. The pairs used for sending and the pairs used for comparison are chosen independently. With both pairs selected for sending, the block emits the pair-one code followed by the pair-two code. A resume-on-any-character option lets any received character restart a paused transmitter. A re-send option repeats the halt code at a fixed interval while the local receiver stays halted.

The serial framer connects to this block through a simple handshake. While `ins_req` is high, the framer takes `ins_char` as soon as it is idle. The framer pops a FIFO byte only when `fifo_ok` is high.

Top module: `xflow_ctrl`

## Requirements
- R1: After synchronous reset, `tx_pause` and `ins_req` are 0, and `fifo_ok` follows `tx_idle`.
- R2: When `tx_mode` is not 0 and `rx_level` exceeds `hi_thr`, `ins_req` rises one clock later carrying the halt code. Mode 1 uses `off1`, mode 2 uses `off2`, and mode 3 uses `off1`. The halt code is requested only once for as long as the level stays above the threshold.
- R3: After a halt has been sent, a level strictly below `lo_thr` requests the resume code of the selected pair, one clock later and only once. A level between the two thresholds requests nothing.
- R4: With `tx_mode` = 3, a sequence sends the pair-one code and then the pair-two code. With `tx_mode` = 0, no code is ever requested.
- R5: A pending insertion advances only on a clock where `tx_idle` is 1. While it waits, `ins_req` and `ins_char` stay stable and `fifo_ok` is 0.
- R6: When `rx_mode` bit 0 is set, a received character equal to `off1` sets `tx_pause` on the next clock. When bit 1 is set, `off2` does the same. A halt code from a pair that is not selected has no effect. While `tx_pause` is 1, `fifo_ok` is 0.
- R7: A received character equal to a resume code of a selected pair clears `tx_pause` on the next clock.
- R8: With `resume_any` = 1, any received character that is not a selected halt code clears `tx_pause`.
- R9: `rx_store` is 1 for a valid character unless the character equals a code of a selected compare pair. With `rx_mode` = 0, every character is stored.
- R10: With `xoff_resend` = 1 and the local receiver halted, the halt code is requested again RESEND_CYC clocks after the previous one was taken. With `xoff_resend` = 0, it is not repeated.
- R11: Setting `rx_mode` to 0 clears `tx_pause` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 2 | Send pair select: 0 none, 1 pair one, 2 pair two, 3 both |
| rx_mode | input | 2 | Compare pair select: bit 0 pair one, bit 1 pair two |
| resume_any | input | 1 | Any received character resumes a paused transmitter |
| xoff_resend | input | 1 | Repeat the halt code while halted |
| on1 | input | 8 | Pair-one resume code |
| off1 | input | 8 | Pair-one halt code |
| on2 | input | 8 | Pair-two resume code |
| off2 | input | 8 | Pair-two halt code |
| rx_level | input | LVL_W | Receive FIFO fill level |
| hi_thr | input | LVL_W | Upper threshold |
| lo_thr | input | LVL_W | Lower threshold |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_idle | input | 1 | Transmitter can accept a character this clock |
| rx_store | output | 1 | Write the received character into the receive FIFO |
| tx_pause | output | 1 | Transmit FIFO draining halted by the far end |
| fifo_ok | output | 1 | Transmitter may pop a FIFO byte this clock |
| ins_req | output | 1 | Insertion of a flow code pending |
| ins_char | output | 8 | Flow code to insert |

## Verification
The threshold side is driven by directed level walks. The level climbs above the upper threshold, sits between the thresholds, and then falls below the lower one, in every send mode. This separates single-shot hysteresis from repeated sends and also shows which pair and order the codes use. Directed runs with the transmitter held busy expose any insertion that slips out before the idle handshake. A re-send run counts the exact interval between halt codes. On the compare side, a seeded random stream draws from all four codes plus arbitrary bytes, under random compare modes and random resume-any settings. A bench model of the pause state and the store decision is checked against the design, and this separates pair selection, halt-over-resume priority and consumption of matched codes.

// File: rtl/xflow_pkg.sv
package xflow_pkg;

    typedef enum logic [1:0] {
        PAIR_NONE = 2'd0,
        PAIR_ONE  = 2'd1,
        PAIR_TWO  = 2'd2,
        PAIR_BOTH = 2'd3
    } pair_sel_e;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_FIRST  = 2'd1,
        SEQ_SECOND = 2'd2
    } seq_state_e;

    typedef enum logic {
        KIND_ON  = 1'b0,
        KIND_OFF = 1'b1
    } flow_kind_e;

    typedef struct packed {
        logic [7:0] on1;
        logic [7:0] off1;
        logic [7:0] on2;
        logic [7:0] off2;
    } flow_codes_t;

    typedef struct packed {
        logic is_on;
        logic is_off;
    } match_t;

    // Code to emit for a given kind, pair selection and position in a two-code run.
    function automatic logic [7:0] pick_code(flow_codes_t c, flow_kind_e k,
                                             pair_sel_e sel, logic second);
        logic use_two;
        use_two = (sel == PAIR_TWO) || ((sel == PAIR_BOTH) && second);
        if (k == KIND_OFF)
            return use_two ? c.off2 : c.off1;
        else
            return use_two ? c.on2 : c.on1;
    endfunction

    // Compare one received character with the selected pairs.
    function automatic match_t classify(flow_codes_t c, pair_sel_e sel, logic [7:0] ch);
        match_t m;
        m.is_off = (sel[0] && ch == c.off1) || (sel[1] && ch == c.off2);
        m.is_on  = (sel[0] && ch == c.on1)  || (sel[1] && ch == c.on2);
        return m;
    endfunction

    function automatic logic two_codes(pair_sel_e sel);
        return sel == PAIR_BOTH;
    endfunction

endpackage

// File: rtl/xflow_rx_gate.sv
module xflow_rx_gate
    import xflow_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pair_sel_e   rx_sel,
    input  flow_codes_t codes,
    input  logic        resume_any,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_store,
    output logic        tx_pause
);
    match_t hit;
    logic   pause_q;

    always_comb begin
        hit      = classify(codes, rx_sel, rx_data);
        rx_store = rx_valid && !(hit.is_on || hit.is_off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_q <= 1'b0;
        end else if (rx_sel == PAIR_NONE) begin
            pause_q <= 1'b0;
        end else if (rx_valid) begin
            if (hit.is_off)
                pause_q <= 1'b1;
            else if (hit.is_on || resume_any)
                pause_q <= 1'b0;
        end
    end

    assign tx_pause = pause_q;
endmodule

// File: rtl/xflow_level_watch.sv
module xflow_level_watch
    import xflow_pkg::*;
#(
    parameter int LVL_W      = 9,
    parameter int RESEND_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             resend_en,
    input  logic             seq_busy,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] hi_thr,
    input  logic [LVL_W-1:0] lo_thr,
    output logic             ev_valid,
    output flow_kind_e       ev_kind
);
    localparam int CNT_W = $clog2(RESEND_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESEND_CYC - 1);

    logic             halted_q;
    logic [CNT_W-1:0] gap_q;
    logic             want_off, want_on, want_again;

    always_comb begin
        want_off   = tx_en && !halted_q && (level > hi_thr);
        want_on    = tx_en &&  halted_q && (level < lo_thr);
        want_again = tx_en &&  halted_q && resend_en && (gap_q == CNT_LAST);
        ev_valid   = !seq_busy && (want_off || want_on || want_again);
        ev_kind    = want_on ? KIND_ON : KIND_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted_q <= 1'b0;
        end else if (!tx_en) begin
            halted_q <= 1'b0;
        end else if (ev_valid) begin
            halted_q <= (ev_kind == KIND_OFF);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_en || !halted_q || !resend_en || seq_busy || ev_valid)
            gap_q <= '0;
        else
            gap_q <= gap_q + 1'b1;
    end
endmodule

// File: rtl/xflow_ins_seq.sv
module xflow_ins_seq
    import xflow_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ev_valid,
    input  flow_kind_e  ev_kind,
    input  pair_sel_e   tx_sel,
    input  flow_codes_t codes,
    input  logic        tx_idle,
    output logic        ins_req,
    output logic [7:0]  ins_char,
    output logic        busy
);
    seq_state_e state_q;
    flow_kind_e kind_q;
    pair_sel_e  sel_q;

    assign busy     = (state_q != SEQ_IDLE);
    assign ins_req  = busy;
    assign ins_char = pick_code(codes, kind_q, sel_q, state_q == SEQ_SECOND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            kind_q  <= KIND_ON;
            sel_q   <= PAIR_NONE;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (ev_valid) begin
                        state_q <= SEQ_FIRST;
                        kind_q  <= ev_kind;
                        sel_q   <= tx_sel;
                    end
                end
                SEQ_FIRST: begin
                    if (tx_idle)
                        state_q <= two_codes(sel_q) ? SEQ_SECOND : SEQ_IDLE;
                end
                SEQ_SECOND: begin
                    if (tx_idle)
                        state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl
    import xflow_pkg::*;
#(
    parameter int LVL_W      = 9,
    parameter int RESEND_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       tx_mode,
    input  logic [1:0]       rx_mode,
    input  logic             resume_any,
    input  logic             xoff_resend,
    input  logic [7:0]       on1,
    input  logic [7:0]       off1,
    input  logic [7:0]       on2,
    input  logic [7:0]       off2,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] hi_thr,
    input  logic [LVL_W-1:0] lo_thr,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             tx_idle,
    output logic             rx_store,
    output logic             tx_pause,
    output logic             fifo_ok,
    output logic             ins_req,
    output logic [7:0]       ins_char
);
    flow_codes_t codes;
    pair_sel_e   tx_sel, rx_sel;
    logic        ev_valid, seq_busy;
    flow_kind_e  ev_kind;

    assign codes  = '{on1: on1, off1: off1, on2: on2, off2: off2};
    assign tx_sel = pair_sel_e'(tx_mode);
    assign rx_sel = pair_sel_e'(rx_mode);

    xflow_rx_gate u_rx_gate (
        .clk        (clk),
        .rst        (rst),
        .rx_sel     (rx_sel),
        .codes      (codes),
        .resume_any (resume_any),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_store   (rx_store),
        .tx_pause   (tx_pause)
    );

    xflow_level_watch #(
        .LVL_W      (LVL_W),
        .RESEND_CYC (RESEND_CYC)
    ) u_level_watch (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_sel != PAIR_NONE),
        .resend_en (xoff_resend),
        .seq_busy  (seq_busy),
        .level     (rx_level),
        .hi_thr    (hi_thr),
        .lo_thr    (lo_thr),
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind)
    );

    xflow_ins_seq u_ins_seq (
        .clk      (clk),
        .rst      (rst),
        .ev_valid (ev_valid),
        .ev_kind  (ev_kind),
        .tx_sel   (tx_sel),
        .codes    (codes),
        .tx_idle  (tx_idle),
        .ins_req  (ins_req),
        .ins_char (ins_char),
        .busy     (seq_busy)
    );

    // Inserted codes win over FIFO bytes; a far-end halt blocks FIFO bytes.
    assign fifo_ok = tx_idle && !tx_pause && !ins_req;
endmodule

// File: rtl/xflow_ctrl_chk.sv
module xflow_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] tx_mode,
    input logic [1:0] rx_mode,
    input logic [7:0] off1,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       tx_idle,
    input logic       rx_store,
    input logic       tx_pause,
    input logic       ins_req,
    input logic [7:0] ins_char
);
    AST_INS_WAIT: assert property (@(posedge clk) disable iff (rst)
        ins_req && !tx_idle |=> ins_req && $stable(ins_char)); // R5

    AST_NO_SEND_OFF: assert property (@(posedge clk) disable iff (rst)
        tx_mode == 2'd0 && !ins_req |=> !ins_req); // R4

    AST_STORE_ALL: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_mode == 2'd0 |-> rx_store); // R9

    AST_HALT_SEEN: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_mode == 2'd1 && rx_data == off1 |=> tx_pause); // R6

    AST_MODE_CLR: assert property (@(posedge clk) disable iff (rst)
        rx_mode == 2'd0 |=> !tx_pause); // R11

    AST_HALT_EATEN: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_mode == 2'd1 && rx_data == off1 |-> !rx_store); // R9
endmodule

bind xflow_ctrl xflow_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_mode  (tx_mode),
    .rx_mode  (rx_mode),
    .off1     (off1),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .tx_idle  (tx_idle),
    .rx_store (rx_store),
    .tx_pause (tx_pause),
    .ins_req  (ins_req),
    .ins_char (ins_char)
);

// File: tb/xflow_ctrl_bench.sv
module xflow_ctrl_bench;
    localparam int LVL_W = 9;
    localparam int RC    = 64;
    localparam logic [7:0] C_ON1 = 8'h11, C_OFF1 = 8'h13, C_ON2 = 8'h21, C_OFF2 = 8'h23;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] tx_mode, rx_mode;
    logic resume_any, xoff_resend, rx_valid, tx_idle;
    logic [7:0] rx_data;
    logic [LVL_W-1:0] rx_level, hi_thr, lo_thr;
    logic rx_store, tx_pause, fifo_ok, ins_req;
    logic [7:0] ins_char;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    xflow_ctrl #(.LVL_W(LVL_W), .RESEND_CYC(RC)) u_xflow_ctrl (
        .clk(clk), .rst(rst), .tx_mode(tx_mode), .rx_mode(rx_mode),
        .resume_any(resume_any), .xoff_resend(xoff_resend),
        .on1(C_ON1), .off1(C_OFF1), .on2(C_ON2), .off2(C_OFF2),
        .rx_level(rx_level), .hi_thr(hi_thr), .lo_thr(lo_thr),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_idle(tx_idle),
        .rx_store(rx_store), .tx_pause(tx_pause), .fifo_ok(fifo_ok),
        .ins_req(ins_req), .ins_char(ins_char)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic m_on(logic [1:0] m, logic [7:0] c);
        return (m[0] && c == C_ON1) || (m[1] && c == C_ON2);
    endfunction

    function automatic logic m_off(logic [1:0] m, logic [7:0] c);
        return (m[0] && c == C_OFF1) || (m[1] && c == C_OFF2);
    endfunction

    // Drive one received character; check the store decision and the pause flag after the edge.
    task automatic send_rx(logic [7:0] c, logic exp_store, logic exp_pause, string req);
        rx_valid = 1'b1;
        rx_data  = c;
        #1;
        chk(req, rx_store, exp_store);
        tick();
        rx_valid = 1'b0;
        chk(req, tx_pause, exp_pause);
    endtask

    logic mp;

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; tx_mode = 2'd0; rx_mode = 2'd0; resume_any = 1'b0; xoff_resend = 1'b0;
        rx_valid = 1'b0; rx_data = 8'h00; tx_idle = 1'b1;
        rx_level = 9'd100; hi_thr = 9'd200; lo_thr = 9'd50;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R1 pause", tx_pause, 0);
        chk("R1 ins_req", ins_req, 0);
        chk("R1 fifo_ok", fifo_ok, 1);

        // ---- threshold side, pair one ----
        tx_idle = 1'b0; tx_mode = 2'd1;
        tick();
        chk("R3 between", ins_req, 0);
        rx_level = 9'd201;
        tick();
        chk("R2 req", ins_req, 1);
        chk("R2 char", ins_char, C_OFF1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R5 wait req", ins_req, 1);
            chk("R5 wait char", ins_char, C_OFF1);
            chk("R5 fifo gate", fifo_ok, 0);
        end
        tx_idle = 1'b1;
        tick();
        chk("R5 taken", ins_req, 0);
        tx_idle = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R2 once", ins_req, 0);
        end
        rx_level = 9'd100;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 between", ins_req, 0);
        end
        rx_level = 9'd50;
        tick();
        chk("R3 equal lo", ins_req, 0);
        rx_level = 9'd49;
        tick();
        chk("R3 req", ins_req, 1);
        chk("R3 char", ins_char, C_ON1);
        tx_idle = 1'b1;
        tick();
        chk("R3 taken", ins_req, 0);
        tick();
        chk("R3 once", ins_req, 0);

        // ---- both pairs ----
        tx_mode = 2'd3; rx_level = 9'd250;
        tick();
        chk("R4 first", ins_char, C_OFF1);
        chk("R4 first req", ins_req, 1);
        tick();
        chk("R4 second", ins_char, C_OFF2);
        chk("R4 second req", ins_req, 1);
        tick();
        chk("R4 done", ins_req, 0);

        // ---- pair two resume ----
        tx_mode = 2'd2; rx_level = 9'd10;
        tick();
        chk("R3 pair2 char", ins_char, C_ON2);
        chk("R3 pair2 req", ins_req, 1);
        tick();
        chk("R3 pair2 taken", ins_req, 0);

        // ---- mode off ----
        tx_mode = 2'd0; rx_level = 9'd300;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk("R4 mode0 silent", ins_req, 0);
        end
        rx_level = 9'd0;
        tick();
        chk("R4 mode0 silent", ins_req, 0);

        // ---- re-send ----
        tx_mode = 2'd1; xoff_resend = 1'b1; rx_level = 9'd201;
        tick();
        chk("R10 first", ins_char, C_OFF1);
        tick();
        chk("R10 taken", ins_req, 0);
        for (int i = 1; i < RC; i++) tick();
        chk("R10 not early", ins_req, 0);
        tick();
        chk("R10 again", ins_req, 1);
        chk("R10 again char", ins_char, C_OFF1);
        xoff_resend = 1'b0;
        tick();
        begin
            int seen = 0;
            for (int i = 0; i < 3 * RC; i++) begin
                tick();
                if (ins_req) seen++;
            end
            chk("R10 off", seen, 0);
        end
        rx_level = 9'd0;
        tick();
        chk("R10 resume", ins_char, C_ON1);
        tick();
        tx_mode = 2'd0;

        // ---- compare side, directed ----
        rx_mode = 2'd1; tx_idle = 1'b1;
        send_rx(C_OFF2, 1, 0, "R6 other pair");
        send_rx(C_OFF1, 0, 1, "R6 halt");
        chk("R6 fifo gate", fifo_ok, 0);
        send_rx(C_ON2, 1, 1, "R7 other pair");
        send_rx(C_ON1, 0, 0, "R7 resume");
        chk("R7 fifo open", fifo_ok, 1);
        send_rx(C_OFF1, 0, 1, "R6 halt");
        send_rx(8'h41, 1, 1, "R8 off");
        resume_any = 1'b1;
        send_rx(C_OFF1, 0, 1, "R8 halt wins");
        send_rx(8'h41, 1, 0, "R8 any");
        send_rx(C_OFF1, 0, 1, "R6 halt");
        rx_mode = 2'd0;
        tick();
        chk("R11 clear", tx_pause, 0);
        send_rx(C_OFF1, 1, 0, "R9 mode0 stored");

        // ---- compare side, random ----
        mp = 1'b0;
        for (int i = 0; i < 600; i++) begin
            logic [1:0] m;
            logic [7:0] c;
            logic v, ra, st;
            int pick;
            m  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) m = 2'd0;
            else if (m == 2'd0) m = 2'd3;
            ra = 1'($urandom_range(0, 1));
            v  = ($urandom_range(0, 4) != 0);
            pick = $urandom_range(0, 5);
            case (pick)
                0: c = C_ON1;
                1: c = C_OFF1;
                2: c = C_ON2;
                3: c = C_OFF2;
                default: c = 8'($urandom_range(0, 255));
            endcase
            rx_mode = m; resume_any = ra; rx_valid = v; rx_data = c;
            st = v && !(m_on(m, c) || m_off(m, c));
            #1;
            chk("R9 random store", rx_store, st);
            if (m == 2'd0) mp = 1'b0;
            else if (v) begin
                if (m_off(m, c)) mp = 1'b1;
                else if (m_on(m, c) || ra) mp = 1'b0;
            end
            tick();
            chk("R6 R7 R8 random pause", tx_pause, mp);
        end
        rx_valid = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule